// File: doc/BRIEF.md
# Low-Side Driver Fault Check Sequencer

This block sits on the controller side of an SPI link to a chain of octal serial low-side drivers. It runs one diagnostic cycle per request. It writes a command word to the chain and waits a fixed settling time for the outputs to react. It then writes the same word again and keeps the diagnostic word that the chain shifts back during that second write. In the command, a 0 bit switches a channel on (pin pulled low) and a 1 bit switches it off.

Each channel is judged by comparing its diagnostic bit with its command bit. A channel that was told to conduct but still reads high is flagged as shorted or overloaded. A channel that was told to stay off but reads low is flagged as an open load. A chain of several devices is handled by widening the word to eight bits per device.

The host raises `start_i` with the command word and waits for the one-cycle `done_o` pulse. The two fault vectors change only on that pulse.

Top module: `fault_check_seq`

## Requirements
- R1: While reset is held and after it is released, `ce_no` is high, `sclk_o` is low, `busy_o` and `done_o` are low, and both fault vectors are zero.
- R2: A `start_i` seen while idle raises `busy_o` on the next cycle. It then runs exactly two transfers, each framed by `ce_no` low and each carrying exactly W = 8*N_DEV SCLK pulses.
- R3: Data goes out MSB (bit W-1) first. `mosi_o` changes only while `sclk_o` is high. `miso_i` is sampled at each SCLK falling edge.
- R4: `sclk_o` is low at every `ce_no` edge, and each SCLK high phase lasts exactly CLK_DIV clocks.
- R5: Both transfers carry the command word that was captured when the cycle started.
- R6: Between the end of the first transfer and the start of the second, `ce_no` stays high for at least SETTLE_CYC clocks.
- R7: `short_o[i]` is set when command bit i is 0 (on) and diagnostic bit i reads 1.
- R8: `open_o[i]` is set when command bit i is 1 (off) and diagnostic bit i reads 0.
- R9: `short_o` and `open_o` never share a set bit. Both vectors change only in the cycle where `done_o` is high. `done_o` is a single-cycle pulse, and it coincides with `busy_o` falling.
- R10: `start_i` and `cmd_i` are ignored while `busy_o` is high. No extra transfer is run, and the words sent do not change.
- R11: In a chain, the first diagnostic bit received belongs to command bit W-1, so a fault on any device maps to the matching flag index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a diagnostic cycle (honoured only when idle) |
| cmd_i | input | 8*N_DEV | Command word; bit value 0 switches the channel on |
| busy_o | output | 1 | Diagnostic cycle in progress |
| done_o | output | 1 | One-cycle pulse when the fault vectors are updated |
| ce_no | output | 1 | Chip enable to the chain, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the chain |
| miso_i | input | 1 | Serial diagnostic data from the chain |
| short_o | output | 8*N_DEV | Per-channel short or overload flag |
| open_o | output | 8*N_DEV | Per-channel open-load flag |

## Verification
Two events can fall in the same cycle: a new `start_i` can arrive in the cycle where the second transfer ends and the fault vectors are loaded. A start can also arrive in the middle of a busy cycle. The bench provokes the second case by pulsing `start_i` with a different word partway through a cycle. It then confirms that only two frames appear, that both carry the original word, and that the flags change only on the `done_o` edge. A behavioural model of the driver chain, with random short and open masks, returns the pin states. From those states the bench computes the expected flags.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_XFER1  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_XFER2  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/fcs_spi_xfer.sv
module fcs_spi_xfer #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] data_i,
  input  logic         miso_i,
  output logic         ce_no,
  output logic         sclk_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o,
  output logic         done_o
);
  localparam int NSTEP = 2 * W + 2;
  localparam int SW    = $clog2(NSTEP + 1);
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;

  logic          active_q;
  logic [SW-1:0] step_q;
  logic [SW-1:0] step_n;
  logic [DW-1:0] div_q;
  logic [W-1:0]  tx_q;
  logic          tick;

  assign tick   = (div_q == DW'(DIV - 1));
  assign step_n = step_q + SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= '0;
      div_q    <= '0;
      tx_q     <= '0;
      rx_o     <= '0;
      ce_no    <= 1'b1;
      sclk_o   <= 1'b0;
      mosi_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          ce_no    <= 1'b0;
          step_q   <= '0;
          div_q    <= '0;
          tx_q     <= data_i;
        end
      end else if (!tick) begin
        div_q <= div_q + DW'(1);
      end else begin
        div_q <= '0;
        if (step_q == SW'(NSTEP - 1)) begin
          active_q <= 1'b0;
          ce_no    <= 1'b1;
          done_o   <= 1'b1;
        end else begin
          step_q <= step_n;
          if (step_n[0] && step_n != SW'(NSTEP - 1)) begin
            // rising edge: present next bit
            sclk_o <= 1'b1;
            mosi_o <= tx_q[W-1];
            tx_q   <= {tx_q[W-2:0], 1'b0};
          end else if (!step_n[0]) begin
            // falling edge: device samples mosi, master samples miso
            sclk_o <= 1'b0;
            rx_o   <= {rx_o[W-2:0], miso_i};
          end
        end
      end
    end
  end

  // R4
  // SCLK only toggles inside a frame
  sclk_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !ce_no);
  // R4
  ce_edge_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce_no) || $rose(ce_no)) |-> !sclk_o);
  // R3
  mosi_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_o && !$past(sclk_o) && !ce_no && !$past(ce_no)) |-> $stable(mosi_o));
endmodule

// File: rtl/fcs_settle_timer.sv
module fcs_settle_timer #(
  parameter int CYC = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic expired_o
);
  localparam int CW = $clog2(CYC + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else begin
      expired_o <= 1'b0;
      if (arm_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == CW'(CYC - 1)) begin
          run_q     <= 1'b0;
          expired_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fcs_classify.sv
module fcs_classify #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cmd_i,
  input  logic [W-1:0] diag_i,
  output logic [W-1:0] short_o,
  output logic [W-1:0] open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      short_o <= '0;
      open_o  <= '0;
    end else if (load_i) begin
      short_o <= ~cmd_i & diag_i;  // on, pin still high
      open_o  <= cmd_i & ~diag_i;  // off, pin not pulled up
    end
  end

  // R9
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_o & open_o) == '0);
  // R9
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(short_o) && $stable(open_o)));
endmodule

// File: rtl/fault_check_seq.sv
module fault_check_seq #(
  parameter int N_DEV      = 1,
  parameter int CLK_DIV    = 25,
  parameter int SETTLE_CYC = 8000,
  localparam int W         = 8 * N_DEV
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] cmd_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         ce_no,
  output logic         sclk_o,
  output logic         mosi_o,
  input  logic         miso_i,
  output logic [W-1:0] short_o,
  output logic [W-1:0] open_o
);
  import fcs_pkg::*;

  seq_state_e state_q;
  logic [W-1:0] cmd_q;
  logic [W-1:0] rx;
  logic [W-1:0] xfer_data;
  logic xfer_go, xfer_done, settled, load;

  assign xfer_go   = (state_q == ST_IDLE && start_i) || (state_q == ST_SETTLE && settled);
  assign xfer_data = (state_q == ST_IDLE) ? cmd_i : cmd_q;
  assign load      = (state_q == ST_XFER2) && xfer_done;
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= load;
      unique case (state_q)
        ST_IDLE:   if (start_i) begin
                     cmd_q   <= cmd_i;
                     state_q <= ST_XFER1;
                   end
        ST_XFER1:  if (xfer_done) state_q <= ST_SETTLE;
        ST_SETTLE: if (settled)   state_q <= ST_XFER2;
        ST_XFER2:  if (xfer_done) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  fcs_spi_xfer #(.W(W), .DIV(CLK_DIV)) u_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (xfer_go),
    .data_i (xfer_data),
    .miso_i (miso_i),
    .ce_no  (ce_no),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .rx_o   (rx),
    .done_o (xfer_done)
  );

  fcs_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (state_q == ST_XFER1 && xfer_done),
    .expired_o (settled)
  );

  fcs_classify #(.W(W)) u_class (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .cmd_i   (cmd_q),
    .diag_i  (rx),
    .short_o (short_o),
    .open_o  (open_o)
  );

  // checker counter: clocks with CE high, saturating
  localparam int HW = $clog2(SETTLE_CYC + 1);
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hi_cnt_q <= '0;
    else if (!ce_no)                      hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(SETTLE_CYC)) hi_cnt_q <= hi_cnt_q + HW'(1);
  end

  // R6
  settle_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce_no) && state_q == ST_XFER2) |-> hi_cnt_q == HW'(SETTLE_CYC));
  // R9
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  no_frame_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ce_no);
endmodule

// File: tb/fault_check_seq_bench.sv
module fault_check_seq_bench;
  localparam int N_DEV  = 2;
  localparam int DIV    = 2;
  localparam int SETTLE = 40;
  localparam int W      = 8 * N_DEV;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] cmd_i = '0;
  logic busy_o, done_o, ce_no, sclk_o, mosi_o, miso_i;
  logic [W-1:0] short_o, open_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  fault_check_seq #(.N_DEV(N_DEV), .CLK_DIV(DIV), .SETTLE_CYC(SETTLE)) u_fault_check_seq (
    .clk_i, .rst_ni, .start_i, .cmd_i, .busy_o, .done_o,
    .ce_no, .sclk_o, .mosi_o, .miso_i, .short_o, .open_o
  );

  // driver chain model
  logic [W-1:0] short_m = '0, open_m = '0;
  logic [W-1:0] latch = '1, sreg = '0, cap = '0, last_frame = '0, prev_frame = '0;
  logic so_q = 1'b0;
  logic ce_p = 1'b1, sclk_p = 1'b0, mosi_p = 1'b0;
  int gap = 0, nbits = 0, frames = 0, hi_len = 0;
  int e_edge = 0, e_gap = 0, e_bits = 0, e_mosi = 0, e_div = 0;

  assign miso_i = so_q;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (ce_p && !ce_no) begin
        if (sclk_o) e_edge <= e_edge + 1;
        if ((frames % 2) == 1 && gap < SETTLE) e_gap <= e_gap + 1;
        sreg  <= (latch & ~open_m) | (~latch & short_m);
        nbits <= 0;
        cap   <= '0;
      end
      if (!ce_p && ce_no) begin
        if (sclk_o) e_edge <= e_edge + 1;
        if (nbits != W) e_bits <= e_bits + 1;
        latch      <= sreg;
        prev_frame <= last_frame;
        last_frame <= cap;
        frames     <= frames + 1;
        gap        <= 1;
      end else if (ce_no) gap <= gap + 1;
      if (!sclk_p && sclk_o) so_q <= sreg[W-1];
      if (sclk_p && !sclk_o) begin
        sreg  <= {sreg[W-2:0], mosi_o};
        cap   <= {cap[W-2:0], mosi_o};
        nbits <= nbits + 1;
        if (hi_len != DIV) e_div <= e_div + 1;
      end
      hi_len <= sclk_o ? hi_len + 1 : 0;
      if (!ce_no && !ce_p && !sclk_o && !sclk_p && mosi_o != mosi_p) e_mosi <= e_mosi + 1;
      ce_p   <= ce_no;
      sclk_p <= sclk_o;
      mosi_p <= mosi_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [W-1:0] cmd, input logic [W-1:0] sm, input logic [W-1:0] om, input bit poke);
    logic [W-1:0] s0, o0;
    int f0, ee, eg, eb, em, ed;
    short_m = sm; open_m = om;
    s0 = short_o; o0 = open_o; f0 = frames;
    ee = e_edge; eg = e_gap; eb = e_bits; em = e_mosi; ed = e_div;
    @(negedge clk_i); cmd_i = cmd; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; cmd_i = ~cmd;
    chk(busy_o == 1'b1, "R2 busy", W'(busy_o), W'(1));
    if (poke) begin
      repeat (7) @(negedge clk_i);
      cmd_i = W'($urandom); start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    while (!done_o) begin
      @(negedge clk_i);
      if (!done_o && (short_o != s0 || open_o != o0))
        chk(1'b0, "R9 flags moved early", short_o, s0);
    end
    chk(frames - f0 == 2, "R2/R10 frame count", W'(frames - f0), W'(2));
    chk(prev_frame == cmd, "R5 first frame word", prev_frame, cmd);
    chk(last_frame == cmd, "R3 second frame word", last_frame, cmd);
    // R11: index i maps to bit i across the whole chain
    chk(short_o == (~cmd & sm), "R7 short", short_o, ~cmd & sm);
    chk(open_o == (cmd & om), "R8 open", open_o, cmd & om);
    chk((short_o & open_o) == '0, "R9 exclusive", short_o & open_o, '0);
    chk(busy_o == 1'b0, "R9 busy drop", W'(busy_o), '0);
    chk(e_edge == ee && e_div == ed, "R4 sclk framing", W'(e_edge - ee + e_div - ed), '0);
    chk(e_mosi == em, "R3 mosi change low", W'(e_mosi - em), '0);
    chk(e_gap == eg, "R6 settle gap", W'(e_gap - eg), '0);
    chk(e_bits == eb, "R2 bit count", W'(e_bits - eb), '0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9 done pulse", W'(done_o), '0);
    repeat (3) @(negedge clk_i);
    chk(ce_no == 1'b1 && frames - f0 == 2, "R10 no queued start", W'(frames - f0), W'(2));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(ce_no && !sclk_o && !busy_o && !done_o, "R1 in reset", {ce_no, sclk_o, busy_o, done_o}, 4'b1000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(ce_no && !sclk_o && !busy_o && !done_o, "R1 after reset", {ce_no, sclk_o, busy_o, done_o}, 4'b1000);
    chk(short_o == '0 && open_o == '0, "R1 flags", short_o | open_o, '0);
    // directed corners
    run('0, '0, '0, 1'b0);                 // all on, clean
    run('1, '0, '0, 1'b0);                 // all off, clean
    run('0, '1, '0, 1'b0);                 // R7 all shorted
    run('1, '0, '1, 1'b0);                 // R8 all open
    run({1'b0, {(W-1){1'b1}}}, W'(1) << (W-1), '0, 1'b0);     // R11 MSB of last device
    run({{(W-1){1'b1}}, 1'b0}, W'(1), '0, 1'b0);              // R11 LSB
    run(W'(16'h00FF), '1, '1, 1'b1);       // R10 poke, both masks
    // random
    for (int i = 0; i < 30; i++)
      run(W'($urandom), W'($urandom), W'($urandom), ($urandom % 3) == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule